// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings so that a memory request can be translated without walking the page table. A 32-bit virtual address is split into a 20-bit virtual page number and a 12-bit page offset. The page number is compared in parallel against every valid entry. Each entry also carries a context tag, so mappings of different processes can sit side by side. On a match the block forms a 30-bit physical address from the stored physical page number and the untranslated offset. It also checks the requested access against the entry's permission bits. The answer is registered and appears one cycle after the request.

When no valid entry matches, the block signals a miss and does not stall. External logic then walks the page table and writes the mapping back through the refill port. A refill goes to the lowest-numbered empty slot. When all slots are full, a slot chosen by a free-running linear feedback shift register is overwritten. A flush input invalidates every entry in one cycle, which serves as the context-switch alternative to tagging. Every lookup that matches updates the status bits of the entry: the reference bit is set, and a permitted write also sets the dirty bit.

Top module: `xlate_buf`

## Requirements
- R1: A request with `req_valid` high that matches a valid entry with equal page number and equal context, and whose access is permitted, gives `rsp_valid`=1 and `rsp_hit`=1 on the next cycle. In that cycle `rsp_pa` = {stored physical page number, `req_va[11:0]`}.
- R2: A request that matches no valid entry gives `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0, `rsp_pa`=0, `rsp_dirty`=0 and `rsp_ref`=0 on the next cycle.
- R3: An entry matches only when its context tag equals `req_ctx`. The same page number under another context misses.
- R4: `req_kind` encodes the access: 00 read, 01 write, 10 execute, 11 reserved. `fill_perm` bit 2 permits read, bit 1 permits write and bit 0 permits execute. Kind 11 is never permitted. A matching request that is not permitted gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_pa`=0.
- R5: `rsp_ref` reports the reference bit of the matched entry as it stood before this request. Any matching request, permitted or faulting, sets that bit. A refill writes the bit as 0.
- R6: `rsp_dirty` reports the dirty bit of the matched entry as it stood before this request. Only a permitted write sets that bit. A faulting write leaves it unchanged. A refill writes it as 0.
- R7: A high `flush` invalidates every entry at the next edge. A refill presented in the same cycle as a flush is dropped.
- R8: A refill is written at the clock edge. A lookup in the same cycle as the refill sees the contents from before the refill, and lookups from the next cycle onward see the new entry.
- R9: While an empty slot exists, a refill goes to an empty slot, so 16 distinct refills after a flush are all retained.
- R10: With every slot full, a refill overwrites exactly one existing entry and keeps the new one.
- R11: After reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_fault` are 0.
- R12: `rsp_valid` is `req_valid` delayed by one cycle. While `req_valid` is low the responses are 0 and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_va | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| req_ctx | input | 4 | Context of the requester |
| flush | input | 1 | Invalidate all entries |
| fill_valid | input | 1 | Write a new mapping |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ctx | input | 4 | Context tag of the new mapping |
| fill_ppn | input | 18 | Physical page number of the new mapping |
| fill_perm | input | 3 | Permissions: bit 2 read, bit 1 write, bit 0 execute |
| rsp_valid | output | 1 | A response is present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Miss exception: no matching entry |
| rsp_fault | output | 1 | Access fault: entry matched, access not permitted |
| rsp_pa | output | 30 | Physical address; 0 unless hit |
| rsp_dirty | output | 1 | Dirty bit of the matched entry before this request |
| rsp_ref | output | 1 | Reference bit of the matched entry before this request |

## Verification
A lookup can fall in the same cycle as a refill or as a flush, and both orderings are provoked on purpose. A directed case refills a mapping and looks it up in that same cycle, where a miss is expected, then looks it up again on the next cycle, where a hit is expected. The random phase also issues a refill alongside a lookup, and the bench model judges the lookup against its contents from before the refill. A flush coincident with a refill is judged by looking up both the old and the dropped mapping afterwards, and both must miss.

// File: rtl/xlb_pkg.sv
package xlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 2;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 0;

  function automatic logic perm_allows(input logic [1:0] kind,
                                       input logic [PERM_W-1:0] perm);
    logic ok;
    case (kind)
      ACC_READ:  ok = perm[PERM_R];
      ACC_WRITE: ok = perm[PERM_W_BIT];
      ACC_EXEC:  ok = perm[PERM_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [7:0] lfsr_taps(input int width);
    logic [7:0] t;
    case (width)
      2: t = 8'b0000_0011;
      3: t = 8'b0000_0110;
      4: t = 8'b0000_1100;
      5: t = 8'b0001_0100;
      6: t = 8'b0011_0000;
      7: t = 8'b0110_0000;
      default: t = 8'b1011_1000;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/xlb_lfsr.sv
module xlb_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  localparam logic [7:0] TAPS8 = xlb_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS = TAPS8[W-1:0];

  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= {{(W-1){1'b0}}, 1'b1};
    else        q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/xlb_match.sv
module xlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int CTX_W = 4,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [N-1:0][CTX_W-1:0] ctxs,
  input  logic [VPN_W-1:0]        look_vpn,
  input  logic [CTX_W-1:0]        look_ctx,
  output logic [N-1:0]            match,
  output logic                    any,
  output logic [IW-1:0]           idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == look_vpn) && (ctxs[i] == look_ctx);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xlb_victim.sv
module xlb_victim #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [IW-1:0] rnd,
  output logic [IW-1:0] slot,
  output logic          has_free
);
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IW'(i);
    end
  end

  assign has_free = ~&valid;
  assign slot     = has_free ? free_idx : rnd;
endmodule

// File: rtl/xlb_store.sv
module xlb_store #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18,
  parameter int CTX_W = 4,
  parameter int PW    = 3,
  localparam int IW   = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_all,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_slot,
  input  logic [VPN_W-1:0]        wr_vpn,
  input  logic [CTX_W-1:0]        wr_ctx,
  input  logic [PPN_W-1:0]        wr_ppn,
  input  logic [PW-1:0]           wr_perm,
  input  logic                    touch_en,
  input  logic                    touch_dirty,
  input  logic [IW-1:0]           touch_idx,
  output logic [N-1:0]            valid,
  output logic [N-1:0]            dirty,
  output logic [N-1:0]            refd,
  output logic [N-1:0][VPN_W-1:0] tags,
  output logic [N-1:0][CTX_W-1:0] ctxs,
  output logic [N-1:0][PPN_W-1:0] ppns,
  output logic [N-1:0][PW-1:0]    perms
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic load, touch;
    assign load  = wr_en && (wr_slot == IW'(i));
    assign touch = touch_en && (touch_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid[i] <= 1'b0;
        dirty[i] <= 1'b0;
        refd[i]  <= 1'b0;
      end else if (clr_all) begin
        valid[i] <= 1'b0;
      end else if (load) begin
        valid[i] <= 1'b1;
        dirty[i] <= 1'b0;
        refd[i]  <= 1'b0;
      end else if (touch) begin
        refd[i] <= 1'b1;
        if (touch_dirty) dirty[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (load) begin
        tags[i]  <= wr_vpn;
        ctxs[i]  <= wr_ctx;
        ppns[i]  <= wr_ppn;
        perms[i] <= wr_perm;
      end
    end
  end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 4,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IW     = $clog2(ENTRIES),
  localparam int PW     = xlb_pkg::PERM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_kind,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [PW-1:0]    fill_perm,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_dirty,
  output logic             rsp_ref
);
  import xlb_pkg::*;

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  logic [ENTRIES-1:0]            ent_valid, ent_dirty, ent_ref;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
  logic [ENTRIES-1:0][CTX_W-1:0] ent_ctx;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0][PW-1:0]    ent_perm;

  logic [ENTRIES-1:0] lk_match;
  logic               lk_any;
  logic [IW-1:0]      lk_idx;
  logic               lk_ok;
  logic               lk_hit, lk_miss, lk_fault;
  logic               upd_en, upd_dirty;
  logic [IW-1:0]      rnd_q, vic_slot;
  logic               vic_free;
  logic               fill_en;

  xlb_lfsr #(.W(IW)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(rnd_q));

  xlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_match (
    .valid(ent_valid), .tags(ent_tag), .ctxs(ent_ctx),
    .look_vpn(req_va[VA_W-1:OFF_W]), .look_ctx(req_ctx),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  xlb_victim #(.N(ENTRIES)) u_victim (
    .valid(ent_valid), .rnd(rnd_q), .slot(vic_slot), .has_free(vic_free)
  );

  assign lk_ok     = perm_allows(req_kind, ent_perm[lk_idx]);
  assign lk_hit    = req_valid && lk_any && lk_ok;
  assign lk_fault  = req_valid && lk_any && !lk_ok;
  assign lk_miss   = req_valid && !lk_any;
  assign upd_en    = req_valid && lk_any;
  assign upd_dirty = lk_hit && (req_kind == ACC_WRITE);
  assign fill_en   = fill_valid && !flush;

  xlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(flush),
    .wr_en(fill_en), .wr_slot(vic_slot), .wr_vpn(fill_vpn), .wr_ctx(fill_ctx),
    .wr_ppn(fill_ppn), .wr_perm(fill_perm),
    .touch_en(upd_en), .touch_dirty(upd_dirty), .touch_idx(lk_idx),
    .valid(ent_valid), .dirty(ent_dirty), .refd(ent_ref),
    .tags(ent_tag), .ctxs(ent_ctx), .ppns(ent_ppn), .perms(ent_perm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_dirty <= 1'b0;
      rsp_ref   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= lk_hit;
      rsp_miss  <= lk_miss;
      rsp_fault <= lk_fault;
      rsp_pa    <= lk_hit ? join_pa(ent_ppn[lk_idx], req_va[OFF_W-1:0]) : '0;
      rsp_dirty <= upd_en && ent_dirty[lk_idx];
      rsp_ref   <= upd_en && ent_ref[lk_idx];
    end
  end
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12,
  parameter int ENTRIES = 16,
  localparam int IW     = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_va,
  input logic [1:0]         req_kind,
  input logic               flush,
  input logic               fill_en,
  input logic [IW-1:0]      vic_slot,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_dirty,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_pa
);
  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));

  a_r2_no_pa_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_pa == '0);

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ent_valid == '0);

  a_r9_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&ent_valid)) |-> !ent_valid[vic_slot]);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_d
    a_r6_dirty_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ent_dirty[i]) |-> $past(req_valid && req_kind == 2'b01));
  end
endmodule

bind xlate_buf xlate_buf_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
  .req_kind(req_kind), .flush(flush), .fill_en(fill_en), .vic_slot(vic_slot),
  .lk_match(lk_match), .ent_valid(ent_valid), .ent_dirty(ent_dirty),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
);

// File: tb/sim_xlate_buf.sv
`timescale 1ns/1ps
module sim_xlate_buf;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_va = 0;
  logic [1:0]  req_kind = 0;
  logic [3:0]  req_ctx = 0;
  logic        flush = 0;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = 0;
  logic [3:0]  fill_ctx = 0;
  logic [17:0] fill_ppn = 0;
  logic [2:0]  fill_perm = 0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty, rsp_ref;
  logic [29:0] rsp_pa;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlate_buf u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_kind(req_kind), .req_ctx(req_ctx), .flush(flush),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
  );

  // bench model of the contents
  bit        m_v [N];
  bit [19:0] m_vpn [N];
  bit [3:0]  m_ctx [N];
  bit [17:0] m_ppn [N];
  bit [2:0]  m_perm [N];
  bit        m_d [N];
  bit        m_r [N];

  function automatic bit allowed(input bit [1:0] k, input bit [2:0] p);
    if (k == 2'd0) return p[2];
    if (k == 2'd1) return p[1];
    if (k == 2'd2) return p[0];
    return 1'b0;
  endfunction

  function automatic int find(input bit [19:0] vpn, input bit [3:0] ctx);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_ctx[i] == ctx) return i;
    return -1;
  endfunction

  function automatic int used();
    int c = 0;
    for (int i = 0; i < N; i++) if (m_v[i]) c++;
    return c;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // set inputs at a negedge; one cycle later sample
  task automatic drive(input bit rv, input bit [31:0] va, input bit [1:0] k, input bit [3:0] c,
                       input bit fv, input bit [19:0] fvpn, input bit [3:0] fc,
                       input bit [17:0] fp, input bit [2:0] fperm, input bit fl);
    req_valid = rv; req_va = va; req_kind = k; req_ctx = c;
    fill_valid = fv; fill_vpn = fvpn; fill_ctx = fc; fill_ppn = fp; fill_perm = fperm;
    flush = fl;
    @(negedge clk);
    req_valid = 0; fill_valid = 0; flush = 0;
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [3:0] c, input bit [17:0] p, input bit [2:0] perm);
    drive(0, 0, 0, 0, 1, vpn, c, p, perm, 0);
  endtask

  task automatic look(input bit [19:0] vpn, input bit [11:0] off, input bit [1:0] k, input bit [3:0] c);
    drive(1, {vpn, off}, k, c, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_flush();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < N; i++) m_v[i] = 0;
  endtask

  task automatic model_fill(input bit [19:0] vpn, input bit [3:0] c, input bit [17:0] p, input bit [2:0] perm);
    for (int i = 0; i < N; i++) if (!m_v[i]) begin
      m_v[i] = 1; m_vpn[i] = vpn; m_ctx[i] = c; m_ppn[i] = p; m_perm[i] = perm;
      m_d[i] = 0; m_r[i] = 0;
      return;
    end
  endtask

  // predict a lookup against the model and update it
  task automatic predict(input bit [19:0] vpn, input bit [11:0] off, input bit [1:0] k, input bit [3:0] c,
                         output bit eh, output bit em, output bit ef, output bit [29:0] epa,
                         output bit ed, output bit er);
    int i = find(vpn, c);
    eh = 0; em = 0; ef = 0; epa = 0; ed = 0; er = 0;
    if (i < 0) em = 1;
    else begin
      ed = m_d[i]; er = m_r[i];
      if (allowed(k, m_perm[i])) begin
        eh = 1; epa = {m_ppn[i], off};
        if (k == 2'd1) m_d[i] = 1;
      end else ef = 1;
      m_r[i] = 1;
    end
  endtask

  task automatic check_rsp(input string tag, input bit eh, input bit em, input bit ef,
                           input bit [29:0] epa, input bit ed, input bit er);
    check({tag, " outcome"}, {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, {1'b1, eh, em, ef});
    check({tag, " pa"}, rsp_pa, epa);
    check({tag, " status"}, {rsp_dirty, rsp_ref}, {ed, er});
  endtask

  task automatic look_chk(input string tag, input bit [19:0] vpn, input bit [11:0] off,
                          input bit [1:0] k, input bit [3:0] c);
    bit eh, em, ef, ed, er; bit [29:0] epa;
    predict(vpn, off, k, c, eh, em, ef, epa, ed, er);
    look(vpn, off, k, c);
    check_rsp(tag, eh, em, ef, epa, ed, er);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R11 idle after reset", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);

    look_chk("R11 R2 empty miss", 20'h12345, 12'h0AB, 2'd0, 4'd3);

    // R8: refill and lookup in the same cycle
    drive(1, {20'h12345, 12'h0AB}, 2'd0, 4'd3, 1, 20'h12345, 4'd3, 18'h2ABCD, 3'b111, 0);
    check_rsp("R8 same-cycle fill sees old", 0, 1, 0, 0, 0, 0);
    model_fill(20'h12345, 4'd3, 18'h2ABCD, 3'b111);

    look_chk("R1 R8 hit next cycle", 20'h12345, 12'hFED, 2'd0, 4'd3);
    look_chk("R5 ref reported set", 20'h12345, 12'h001, 2'd0, 4'd3);
    look_chk("R6 first write", 20'h12345, 12'h002, 2'd1, 4'd3);
    look_chk("R6 dirty after write", 20'h12345, 12'h003, 2'd2, 4'd3);
    look_chk("R3 other context misses", 20'h12345, 12'h003, 2'd0, 4'd4);
    look_chk("R4 reserved kind faults", 20'h12345, 12'h004, 2'd3, 4'd3);

    fill(20'h00077, 4'd1, 18'h00100, 3'b100); model_fill(20'h00077, 4'd1, 18'h00100, 3'b100);
    look_chk("R4 write to read-only faults", 20'h00077, 12'h010, 2'd1, 4'd1);
    look_chk("R6 R5 faulting write no dirty", 20'h00077, 12'h011, 2'd0, 4'd1);
    look_chk("R4 exec not allowed", 20'h00077, 12'h012, 2'd2, 4'd1);

    // R12: write kind without req_valid changes nothing
    fill(20'h00C00, 4'd2, 18'h3FFFF, 3'b110); model_fill(20'h00C00, 4'd2, 18'h3FFFF, 3'b110);
    drive(0, {20'h00C00, 12'h0}, 2'd1, 4'd2, 0, 0, 0, 0, 0, 0);
    check("R12 no response when idle", {rsp_valid, rsp_hit, rsp_miss, rsp_fault}, 0);
    look_chk("R12 idle left status clear", 20'h00C00, 12'hABC, 2'd0, 4'd2);

    // R7: flush with coincident refill
    drive(0, 0, 0, 0, 1, 20'h0BEEF, 4'd5, 18'h1, 3'b111, 1);
    for (int i = 0; i < N; i++) m_v[i] = 0;
    look_chk("R7 flushed entry misses", 20'h12345, 12'h0, 2'd0, 4'd3);
    look_chk("R7 flushed entry2 misses", 20'h00C00, 12'h0, 2'd0, 4'd2);
    look_chk("R7 dropped fill misses", 20'h0BEEF, 12'h0, 2'd0, 4'd5);

    // R9: 16 distinct fills all retained
    for (int i = 0; i < N; i++) begin
      fill(20'h40000 + 20'(i * 7), 4'(i), 18'h10000 + 18'(i), 3'b111);
      model_fill(20'h40000 + 20'(i * 7), 4'(i), 18'h10000 + 18'(i), 3'b111);
    end
    for (int i = 0; i < N; i++)
      look_chk("R9 all retained", 20'h40000 + 20'(i * 7), 12'h5A5, 2'd0, 4'(i));

    // R10: one more fill when full
    fill(20'h55555, 4'd9, 18'h2AAAA, 3'b111);
    begin
      int hits = 0;
      look(20'h55555, 12'h123, 2'd0, 4'd9);
      check("R10 new entry hits", {rsp_hit, rsp_pa}, {1'b1, 18'h2AAAA, 12'h123});
      for (int i = 0; i < N; i++) begin
        look(20'h40000 + 20'(i * 7), 12'h0, 2'd0, 4'(i));
        if (rsp_hit) hits++;
      end
      check("R10 exactly one evicted", hits, N - 1);
    end

    // random phase
    do_flush();
    begin
      bit eh, em, ef, ed, er; bit [29:0] epa;
      void'($urandom(32'h5EED1234));
      for (int it = 0; it < 600; it++) begin
        bit dofill, dolook;
        bit [19:0] lv; bit [3:0] lc; bit [1:0] lk; bit [11:0] lo;
        bit [19:0] fv; bit [3:0] fc; bit [17:0] fp; bit [2:0] fpm;
        if (used() == N && ($urandom % 40) == 0) do_flush();
        dofill = (used() < N) && (($urandom % 4) == 0);
        dolook = ($urandom % 5) != 0;
        fv = 20'($urandom % 64); fc = 4'($urandom % 4);
        fp = 18'($urandom); fpm = 3'($urandom);
        if (find(fv, fc) >= 0) dofill = 0;
        if (used() > 0 && ($urandom % 10) < 7) begin
          int j;
          do j = $urandom % N; while (!m_v[j]);
          lv = m_vpn[j]; lc = m_ctx[j];
        end else begin
          lv = 20'($urandom % 64); lc = 4'($urandom % 4);
        end
        lk = 2'($urandom); lo = 12'($urandom);
        if (dolook) predict(lv, lo, lk, lc, eh, em, ef, epa, ed, er);
        drive(dolook, {lv, lo}, lk, lc, dofill, fv, fc, fp, fpm, 0);
        if (dofill) model_fill(fv, fc, fp, fpm);
        if (dolook) check_rsp("R1 R2 R4 R5 R6 R8 random", eh, em, ef, epa, ed, er);
        else check("R12 random idle", rsp_valid, 0);
      end
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule